// File: doc/BRIEF.md
# Byte-Indexed Table Lookup Unit

The unit assembles a 32-bit word from four byte lanes of an index word. Each lane holds an unsigned byte that points into a small table of bytes. The table is built from one to four 64-bit doublewords, presented side by side on one wide input. Doubleword 0 sits in the least significant bits.

A lane whose index falls inside the active table length returns the addressed table byte. A lane whose index does not fall inside it returns the byte in the same lane position of a separate fallback word. Each lane decides this without regard to the others. Driving the fallback word with zero gives the form of the lookup that zeroes out-of-range lanes. Driving it with the previous destination value gives the form that leaves those lanes unchanged.

The result is captured in an output register when the enable input is high. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bytelut_unit`

## Requirements
- R1: The index word is split into four independent byte lanes at bits [7:0], [15:8], [23:16] and [31:24], and each lane's index affects only the matching byte of the result.
- R2: A lane index is in range only when it is strictly below the active table length in bytes. An index equal to the length is out of range, and so is 255.
- R3: An in-range index i returns table byte i, which is bits [8*i+7:8*i] of `tbl_bits`. That byte is byte i%8, counted from the least significant end, of doubleword i/8.
- R4: An out-of-range index returns the fallback word's byte in the same lane position.
- R5: `len_sel` selects the table length as (len_sel+1)*8 bytes, so the codes 0, 1, 2 and 3 give 8, 16, 24 and 32 bytes.
- R6: The result register loads the lookup one clock edge after `en` is sampled high, and it keeps its value on any edge where `en` is low.
- R7: While reset is asserted the result reads zero, and the register stays at zero until the first enabled edge after reset is released.
- R8: With a zero fallback word, out-of-range lanes read zero. With the old destination passed as the fallback, those lanes keep their old bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| en | input | 1 | Clock enable for the result register |
| len_sel | input | 2 | Table length code: (len_sel+1) doublewords |
| idx_word | input | 32 | Four byte-wide lane indexes |
| dflt_word | input | 32 | Fallback bytes for out-of-range lanes |
| tbl_bits | input | 256 | Table bytes, doubleword 0 in the low 64 bits |
| result | output | 32 | Registered lookup result |

## Verification
The bench uses a table in which every byte is distinct, so any wrong doubleword or wrong byte position shows up as a wrong value. It moves the three boundary indexes (length-1, length and 255) through every lane at every length. While it does so, the other lanes carry in-range indexes, which shows that each lane decides on its own and that the compare is strict. Separate patterns test three more points. An identity index sequence tests the byte ordering. Zero and old-destination fallback words tell the two lookup forms apart. A pattern that changes the inputs while `en` is low tells a held register from one that follows its inputs.

// File: rtl/bytelut_pkg.sv
package bytelut_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DWORD_W = 64;
  localparam int unsigned DWORD_B = DWORD_W / BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bytelut_limit.sv
module bytelut_limit #(
  parameter int unsigned DW_COUNT = 4,
  localparam int unsigned LSELW = (DW_COUNT > 1) ? $clog2(DW_COUNT) : 1,
  localparam int unsigned LIMW  = $clog2(DW_COUNT * bytelut_pkg::DWORD_B + 1)
) (
  input  logic [LSELW-1:0] len_sel,
  output logic [LIMW-1:0]  byte_limit
);
  import bytelut_pkg::*;

  always_comb begin
    byte_limit = LIMW'((32'(len_sel) + 32'd1) * DWORD_B);
  end

  // The length is always a whole, nonzero number of doublewords.
  always_comb begin
    AST_LIMIT_WHOLE_DW: assert (byte_limit != '0 && (32'(byte_limit) % DWORD_B) == 0)
      else $error("length not a doubleword multiple"); // R5
  end
endmodule

// File: rtl/bytelut_lane.sv
module bytelut_lane #(
  parameter int unsigned DW_COUNT = 4,
  parameter int unsigned LIMW = 6,
  localparam int unsigned TBL_W = DW_COUNT * bytelut_pkg::DWORD_W,
  localparam int unsigned CMPW  = (LIMW > 8) ? LIMW : 8
) (
  input  bytelut_pkg::byte_t idx,
  input  bytelut_pkg::byte_t dflt,
  input  logic [TBL_W-1:0]   tbl_bits,
  input  logic [LIMW-1:0]    byte_limit,
  output bytelut_pkg::byte_t lane_out
);
  import bytelut_pkg::*;

  logic               in_range;
  logic [DWORD_W-1:0] dword_sel;
  byte_t              tbl_byte;

  // Range test: strictly less than the active byte length.
  always_comb begin
    in_range = (CMPW'(idx) < CMPW'(byte_limit));
  end

  // First level: pick the doubleword by the upper index bits.
  always_comb begin
    dword_sel = '0;
    for (int d = 0; d < int'(DW_COUNT); d++) begin
      if (int'(idx[7:3]) == d) begin
        dword_sel = tbl_bits[d*DWORD_W +: DWORD_W];
      end
    end
  end

  // Second level: pick the byte inside the doubleword, LSB first.
  always_comb begin
    tbl_byte = byte_t'(dword_sel >> {idx[2:0], 3'b000});
  end

  always_comb begin
    lane_out = in_range ? tbl_byte : dflt;
  end
endmodule

// File: rtl/bytelut_unit.sv
module bytelut_unit #(
  parameter int unsigned DW_COUNT = 4,
  parameter int unsigned LANES    = 4,
  localparam int unsigned LSELW = (DW_COUNT > 1) ? $clog2(DW_COUNT) : 1,
  localparam int unsigned TBL_W = DW_COUNT * bytelut_pkg::DWORD_W,
  localparam int unsigned WORD_W = LANES * bytelut_pkg::BYTE_W,
  localparam int unsigned LIMW  = $clog2(DW_COUNT * bytelut_pkg::DWORD_B + 1),
  localparam int unsigned CMPW  = (LIMW > 8) ? LIMW : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LSELW-1:0]  len_sel,
  input  logic [WORD_W-1:0] idx_word,
  input  logic [WORD_W-1:0] dflt_word,
  input  logic [TBL_W-1:0]  tbl_bits,
  output logic [WORD_W-1:0] result
);
  import bytelut_pkg::*;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  always_comb begin
    rst_q_n = rst_pipe[1];
  end

  logic [LIMW-1:0] byte_limit;

  bytelut_limit #(.DW_COUNT(DW_COUNT)) u_limit (
    .len_sel    (len_sel),
    .byte_limit (byte_limit)
  );

  logic [WORD_W-1:0] lookup_word;

  for (genvar g = 0; g < int'(LANES); g++) begin : gen_lane
    bytelut_lane #(.DW_COUNT(DW_COUNT), .LIMW(LIMW)) u_lane (
      .idx        (idx_word[g*BYTE_W +: BYTE_W]),
      .dflt       (dflt_word[g*BYTE_W +: BYTE_W]),
      .tbl_bits   (tbl_bits),
      .byte_limit (byte_limit),
      .lane_out   (lookup_word[g*BYTE_W +: BYTE_W])
    );

    AST_LANE_FALLBACK: assert property (@(posedge clk) disable iff (!rst_q_n)
      (en && (CMPW'(idx_word[g*BYTE_W +: BYTE_W]) >= CMPW'(byte_limit)))
      |=> result[g*BYTE_W +: BYTE_W] == $past(dflt_word[g*BYTE_W +: BYTE_W]))
      else $error("lane fallback byte wrong"); // R4

    AST_LANE_PICK: assert property (@(posedge clk) disable iff (!rst_q_n)
      (en && (CMPW'(idx_word[g*BYTE_W +: BYTE_W]) < CMPW'(byte_limit)))
      |=> result[g*BYTE_W +: BYTE_W] ==
          $past(tbl_bits[BYTE_W * int'(idx_word[g*BYTE_W +: BYTE_W]) +: BYTE_W]))
      else $error("lane table byte wrong"); // R3
  end

  // Result register with explicit clock enable.
  logic [WORD_W-1:0] result_nx;
  logic [WORD_W-1:0] result_q;

  always_comb begin
    result_nx = result_q;
    if (en) begin
      result_nx = lookup_word;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result_q <= '0;
    end else begin
      result_q <= result_nx;
    end
  end

  always_comb begin
    result = result_q;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en |=> $stable(result))
    else $error("result moved without enable"); // R6
endmodule

// File: tb/tb_bytelut_unit.sv
module tb_bytelut_unit;
  logic         clk;
  logic         rst_n;
  logic         en;
  logic [1:0]   len_sel;
  logic [31:0]  idx_word;
  logic [31:0]  dflt_word;
  logic [255:0] tbl_bits;
  logic [31:0]  result;

  int checks = 0;
  int errors = 0;

  bytelut_unit dut (
    .clk(clk), .rst_n(rst_n), .en(en), .len_sel(len_sel),
    .idx_word(idx_word), .dflt_word(dflt_word), .tbl_bits(tbl_bits),
    .result(result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] idx, input logic [31:0] dflt,
                                        input logic [1:0] ls);
    logic [31:0] r;
    int lim;
    lim = (int'(ls) + 1) * 8;
    for (int l = 0; l < 4; l++) begin
      int b;
      b = int'(idx[8*l +: 8]);
      if (b < lim) r[8*l +: 8] = tbl_bits[8*b +: 8];
      else         r[8*l +: 8] = dflt[8*l +: 8];
    end
    return r;
  endfunction

  task automatic lookup(input logic [1:0] ls, input logic [31:0] idx, input logic [31:0] dflt);
    @(negedge clk);
    en = 1'b1; len_sel = ls; idx_word = idx; dflt_word = dflt;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b1; len_sel = 2'd3; idx_word = 32'h03020100;
    dflt_word = 32'hFFFFFFFF;
    repeat (3) @(posedge clk);
    #1 chk("R7 during reset", result, 32'h0);
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R7 after release, no enable", result, 32'h0);
  endtask

  task automatic t_identity;
    lookup(2'd3, 32'h03020100, 32'h0);
    chk("R3 bytes 0..3", result, {tbl_bits[31:24], tbl_bits[23:16], tbl_bits[15:8], tbl_bits[7:0]});
    lookup(2'd3, 32'h1F180F08, 32'h0);
    chk("R3 doubleword edges", result, {tbl_bits[255:248], tbl_bits[199:192], tbl_bits[127:120], tbl_bits[71:64]});
  endtask

  task automatic t_boundaries;
    for (int ls = 0; ls < 4; ls++) begin
      for (int lane = 0; lane < 4; lane++) begin
        int len;
        logic [31:0] base;
        len = (ls + 1) * 8;
        base = 32'h05040302;
        for (int k = 0; k < 3; k++) begin
          logic [31:0] idx;
          logic [7:0]  b;
          b = (k == 0) ? 8'(len - 1) : (k == 1) ? 8'(len) : 8'hFF;
          idx = base;
          idx[8*lane +: 8] = b;
          lookup(2'(ls), idx, 32'hD5C3B2A1);
          chk($sformatf("R2 R4 R1 len=%0d lane=%0d idx=%0d", len, lane, b),
              result, model(idx, 32'hD5C3B2A1, 2'(ls)));
        end
      end
    end
  endtask

  task automatic t_length_codes;
    lookup(2'd0, 32'h08080808, 32'hA0A1A2A3);
    chk("R5 code0 length 8", result, 32'hA0A1A2A3);
    lookup(2'd1, 32'h10100808, 32'hA0A1A2A3);
    chk("R5 code1 length 16", result, {16'hA0A1, tbl_bits[71:64], tbl_bits[71:64]});
    lookup(2'd2, 32'h18181717, 32'hA0A1A2A3);
    chk("R5 code2 length 24", result, {16'hA0A1, tbl_bits[191:184], tbl_bits[191:184]});
  endtask

  task automatic t_forms;
    lookup(2'd1, 32'h40011180, 32'h0);
    chk("R8 zeroing form", result, {8'h00, tbl_bits[15:8], 8'h00, 8'h00});
    lookup(2'd1, 32'h40011180, 32'h11223344);
    chk("R8 keep-destination form", result, {8'h11, tbl_bits[15:8], 8'h33, 8'h44});
    lookup(2'd3, 32'h20061F40, 32'hCAFEF00D);
    chk("R1 mixed lanes", result, {8'hCA, tbl_bits[55:48], tbl_bits[255:248], 8'h0D});
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    lookup(2'd3, 32'h0A0B0C0D, 32'h0);
    prev = result;
    chk("R6 load on enable", prev, model(32'h0A0B0C0D, 32'h0, 2'd3));
    @(negedge clk);
    en = 1'b0; idx_word = 32'hFFFF0000; dflt_word = 32'h12345678;
    repeat (3) @(posedge clk);
    #1 chk("R6 hold without enable", result, prev);
    @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    #1 chk("R6 reload", result, model(32'hFFFF0000, 32'h12345678, 2'd3));
  endtask

  initial begin
    for (int k = 0; k < 32; k++) tbl_bits[8*k +: 8] = 8'(k * 29 + 3);
    t_reset();
    t_identity();
    t_boundaries();
    t_length_codes();
    t_forms();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule